// File: doc/BRIEF.md
# 4x4 Block Pipeline Sequencer

This block controls a three-stage pipeline that rebuilds one macroblock from its 4x4 blocks: an entropy decode stage, an inverse quantisation and transform stage, and an intra prediction stage. It hands block indices out in decoding order. Each stage gets a one-cycle start pulse with the index and kind of the block it is to work on. The stage answers with a one-cycle done pulse when it has finished. Blocks move forward one at a time, so stage k+1 can work on block n while stage k works on block n+1. Only one block sits at each stage boundary, never a whole macroblock.

The entropy stage can take any number of cycles per block, and a slow stage holds everything behind it without losing a block. An optional leading luma DC block is sequenced only when the macroblock type says it is present. For inter macroblocks the intra prediction stage is skipped entirely, and blocks retire from the transform stage. The macroblock-done pulse marks the retirement of the final Cr block. The block is then free for the next macroblock start.

Top module: `blk4_pipe_seq`

## Requirements
- R1: After reset, and until a macroblock start is accepted, all three stage start outputs and the macroblock-done output stay low.
- R2: The entropy stage receives each block of the macroblock once, in rising slot order. The slot numbers are: 0 luma DC, 1 to 16 luma, 17 and 18 chroma DC, 19 to 22 Cb, 23 to 26 Cr. The slot number is placed on the index output with each start.
- R3: Each start carries a kind code that matches its slot: 0 luma DC, 1 luma, 2 chroma DC, 3 Cb, 4 Cr.
- R4: When the luma-DC-present flag is high at the accepted start, the first block is slot 0. When the flag is low, the first block is slot 1 and slot 0 is never issued.
- R5: The transform stage receives every block that the entropy stage finished, in the same order. For intra macroblocks the intra prediction stage also receives every block, in the same order.
- R6: A stage never gets a start pulse between its previous start and the done pulse that answers it.
- R7: When the inter flag is high at the accepted start, the intra prediction stage receives no start for that macroblock.
- R8: Macroblock done is high for exactly one cycle, the cycle after the final active stage signals done for slot 26.
- R9: A macroblock start pulse that arrives while a macroblock is in progress is ignored, whatever flags come with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_start | input | 1 | Macroblock start pulse |
| mb_has_ldc | input | 1 | Luma DC block present, sampled with mb_start |
| mb_is_inter | input | 1 | Inter macroblock: skip intra stage, sampled with mb_start |
| ent_start | output | 1 | Entropy stage start pulse |
| ent_idx | output | 5 | Entropy stage block slot |
| ent_kind | output | 3 | Entropy stage block kind |
| ent_done | input | 1 | Entropy stage done pulse |
| iqt_start | output | 1 | Transform stage start pulse |
| iqt_idx | output | 5 | Transform stage block slot |
| iqt_kind | output | 3 | Transform stage block kind |
| iqt_done | input | 1 | Transform stage done pulse |
| ipr_start | output | 1 | Intra stage start pulse |
| ipr_idx | output | 5 | Intra stage block slot |
| ipr_kind | output | 3 | Intra stage block kind |
| ipr_done | input | 1 | Intra stage done pulse |
| mb_done | output | 1 | Macroblock retired pulse |

## Verification
The bench targets long entropy latencies that back up the whole pipe. If a design handed a block to a stage that was still busy, a stage would receive a start before its done. If it dropped the held block, the scoreboard would see a skipped slot. Both settings of the luma DC flag and of the inter flag are run. Getting the flag wrong would show as a stray slot 0, or as intra starts on an inter macroblock, or as a done pulse that waits for a stage that never runs. A second start pulse with inverted flags is sent in the middle of a macroblock. A design that accepted it would restart the slot count or change which stage is final.

// File: rtl/blk4_pipe_seq.sv
module blk4_pipe_seq #(
  parameter int IDX_W  = 5,
  parameter int KIND_W = 3,
  parameter int N_LUMA = 16,
  parameter int N_CDC  = 2,
  parameter int N_CHR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mb_start,
  input  logic              mb_has_ldc,
  input  logic              mb_is_inter,
  output logic              ent_start,
  output logic [IDX_W-1:0]  ent_idx,
  output logic [KIND_W-1:0] ent_kind,
  input  logic              ent_done,
  output logic              iqt_start,
  output logic [IDX_W-1:0]  iqt_idx,
  output logic [KIND_W-1:0] iqt_kind,
  input  logic              iqt_done,
  output logic              ipr_start,
  output logic [IDX_W-1:0]  ipr_idx,
  output logic [KIND_W-1:0] ipr_kind,
  input  logic              ipr_done,
  output logic              mb_done
);
  localparam int CDC_B = N_LUMA + 1;
  localparam int CB_B  = CDC_B + N_CDC;
  localparam int CR_B  = CB_B + N_CHR;
  localparam int LAST  = CR_B + N_CHR - 1;
  localparam logic [IDX_W-1:0] CDC_I  = IDX_W'(CDC_B);
  localparam logic [IDX_W-1:0] CB_I   = IDX_W'(CB_B);
  localparam logic [IDX_W-1:0] CR_I   = IDX_W'(CR_B);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST);

  function automatic logic [KIND_W-1:0] kind_of(input logic [IDX_W-1:0] s);
    if (s == '0)        return KIND_W'(0);
    else if (s < CDC_I) return KIND_W'(1);
    else if (s < CB_I)  return KIND_W'(2);
    else if (s < CR_I)  return KIND_W'(3);
    else                return KIND_W'(4);
  endfunction

  logic act, inter_q;
  logic [IDX_W-1:0] nxt;
  logic b0, f0, b1, f1, b2;

  wire accept = mb_start & ~act;
  wire go0 = act & ~b0 & ~f0 & (nxt <= LAST_I);
  wire go1 = f0 & ~b1 & ~f1;
  wire go2 = f1 & ~b2;
  wire d0  = ent_done & b0;
  wire d1  = iqt_done & b1;
  wire d2  = ipr_done & b2;
  wire fin = inter_q ? d1 : d2;
  wire [IDX_W-1:0] fin_idx = inter_q ? iqt_idx : ipr_idx;
  wire last = fin & (fin_idx == LAST_I);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; inter_q <= 1'b0; nxt <= '0;
      b0 <= 1'b0; f0 <= 1'b0; b1 <= 1'b0; f1 <= 1'b0; b2 <= 1'b0;
      ent_start <= 1'b0; iqt_start <= 1'b0; ipr_start <= 1'b0; mb_done <= 1'b0;
      ent_idx <= '0; iqt_idx <= '0; ipr_idx <= '0;
      ent_kind <= '0; iqt_kind <= '0; ipr_kind <= '0;
    end else begin
      ent_start <= go0;
      iqt_start <= go1;
      ipr_start <= go2;
      mb_done   <= last;

      if (accept) begin
        act     <= 1'b1;
        inter_q <= mb_is_inter;
        nxt     <= mb_has_ldc ? '0 : IDX_W'(1);
      end else if (last) begin
        act <= 1'b0;
      end

      if (go0) begin
        b0       <= 1'b1;
        nxt      <= nxt + 1'b1;
        ent_idx  <= nxt;
        ent_kind <= kind_of(nxt);
      end else if (d0) begin
        b0 <= 1'b0;
        f0 <= 1'b1;
      end

      if (go1) begin
        f0       <= 1'b0;
        b1       <= 1'b1;
        iqt_idx  <= ent_idx;
        iqt_kind <= ent_kind;
      end

      if (d1) begin
        b1 <= 1'b0;
        f1 <= ~inter_q;
      end

      if (go2) begin
        f1       <= 1'b0;
        b2       <= 1'b1;
        ipr_idx  <= iqt_idx;
        ipr_kind <= iqt_kind;
      end

      if (d2) b2 <= 1'b0;
    end
  end
endmodule

// File: rtl/blk4_pipe_seq_chk.sv
module blk4_pipe_seq_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ent_start,
  input logic [IDX_W-1:0] ent_idx,
  input logic             ent_done,
  input logic             iqt_start,
  input logic             iqt_done,
  input logic             ipr_start,
  input logic             ipr_done,
  input logic             mb_done,
  input logic             inter_q
);
  logic e_busy, t_busy, p_busy, e_any;
  logic [IDX_W-1:0] e_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_busy <= 1'b0; t_busy <= 1'b0; p_busy <= 1'b0;
      e_any <= 1'b0; e_last <= '0;
    end else begin
      if (ent_start) e_busy <= 1'b1; else if (ent_done) e_busy <= 1'b0;
      if (iqt_start) t_busy <= 1'b1; else if (iqt_done) t_busy <= 1'b0;
      if (ipr_start) p_busy <= 1'b1; else if (ipr_done) p_busy <= 1'b0;
      if (mb_done) e_any <= 1'b0;
      else if (ent_start) begin e_any <= 1'b1; e_last <= ent_idx; end
    end
  end

  // R6
  ent_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n) ent_start |-> !e_busy);
  // R6
  iqt_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n) iqt_start |-> !t_busy);
  // R6
  ipr_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n) ipr_start |-> !p_busy);
  // R7
  intra_off_chk: assert property (@(posedge clk) disable iff (!rst_n) inter_q |-> !ipr_start);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mb_done |=> !mb_done);
  // R2
  ent_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_start && e_any) |-> (ent_idx == e_last + 1'b1));
endmodule

bind blk4_pipe_seq blk4_pipe_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ent_start(ent_start), .ent_idx(ent_idx), .ent_done(ent_done),
  .iqt_start(iqt_start), .iqt_done(iqt_done),
  .ipr_start(ipr_start), .ipr_done(ipr_done),
  .mb_done(mb_done), .inter_q(inter_q)
);

// File: tb/sim_blk4_pipe_seq.sv
module sim_blk4_pipe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IQT_LAT = 4;
  localparam int IPR_LAT = 3;
  localparam int LAST = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mb_start = 1'b0, mb_has_ldc = 1'b0, mb_is_inter = 1'b0;
  logic ent_done = 1'b0, iqt_done = 1'b0, ipr_done = 1'b0;
  logic ent_start, iqt_start, ipr_start, mb_done;
  logic [4:0] ent_idx, iqt_idx, ipr_idx;
  logic [2:0] ent_kind, iqt_kind, ipr_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk4_pipe_seq u0 (
    .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .mb_has_ldc(mb_has_ldc),
    .mb_is_inter(mb_is_inter),
    .ent_start(ent_start), .ent_idx(ent_idx), .ent_kind(ent_kind), .ent_done(ent_done),
    .iqt_start(iqt_start), .iqt_idx(iqt_idx), .iqt_kind(iqt_kind), .iqt_done(iqt_done),
    .ipr_start(ipr_start), .ipr_idx(ipr_idx), .ipr_kind(ipr_kind), .ipr_done(ipr_done),
    .mb_done(mb_done)
  );

  int vecs = 0, errs = 0;
  int q0[$], q1[$], q2[$];
  int mbd_cnt = 0, ipr_cnt = 0, first_exp = -1;
  bit cur_inter = 0, fin_prev = 0, bz0 = 0, bz1 = 0, bz2 = 0, live = 0;
  int c0 = 0, c1 = 0, c2 = 0, x1 = 0, x2 = 0;

  function automatic int kind_of(int s);
    if (s == 0) return 0;
    if (s <= 16) return 1;
    if (s <= 18) return 2;
    if (s <= 22) return 3;
    return 4;
  endfunction

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic pop_cmp(ref int q[$], input int idx, input int kd, input string req);
    if (q.size() == 0) chk(1'b0, req, idx, -1);
    else begin
      int e;
      e = q.pop_front();
      chk(idx == e, req, idx, e);
      chk(kd == kind_of(e), "R3", kd, kind_of(e));
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      bit fin_now;
      fin_now = 0;
      if (mb_done || fin_prev) begin
        chk(mb_done == fin_prev, "R8", mb_done, fin_prev);
        if (mb_done) mbd_cnt++;
      end
      ent_done = 0; iqt_done = 0; ipr_done = 0;
      if (bz0) begin c0--; if (c0 == 0) begin ent_done = 1; bz0 = 0; end end
      if (bz1) begin
        c1--;
        if (c1 == 0) begin iqt_done = 1; bz1 = 0; if (cur_inter && x1 == LAST) fin_now = 1; end
      end
      if (bz2) begin
        c2--;
        if (c2 == 0) begin ipr_done = 1; bz2 = 0; if (!cur_inter && x2 == LAST) fin_now = 1; end
      end
      if (ent_start) begin
        chk(!bz0, "R6", 1, 0);
        if (first_exp >= 0) begin
          chk(int'(ent_idx) == first_exp, "R4", ent_idx, first_exp);
          first_exp = -1;
        end
        pop_cmp(q0, ent_idx, ent_kind, "R2");
        bz0 = 1; c0 = $urandom_range(40, 1);
      end
      if (iqt_start) begin
        chk(!bz1, "R6", 1, 0);
        pop_cmp(q1, iqt_idx, iqt_kind, "R5");
        bz1 = 1; c1 = IQT_LAT; x1 = iqt_idx;
      end
      if (ipr_start) begin
        ipr_cnt++;
        chk(!bz2, "R6", 1, 0);
        pop_cmp(q2, ipr_idx, ipr_kind, cur_inter ? "R7" : "R5");
        bz2 = 1; c2 = IPR_LAT; x2 = ipr_idx;
      end
      fin_prev = fin_now;
    end
  end

  task automatic run_mb(bit ldc, bit inter, bit poke);
    int prev;
    prev = mbd_cnt;
    for (int s = (ldc ? 0 : 1); s <= LAST; s++) begin
      q0.push_back(s);
      q1.push_back(s);
      if (!inter) q2.push_back(s);
    end
    cur_inter = inter;
    first_exp = ldc ? 0 : 1;
    ipr_cnt = 0;
    @(negedge clk);
    mb_start = 1; mb_has_ldc = ldc; mb_is_inter = inter;
    @(negedge clk);
    mb_start = 0;
    if (poke) begin
      repeat (60) @(negedge clk);
      mb_start = 1; mb_has_ldc = ~ldc; mb_is_inter = ~inter;
      @(negedge clk);
      mb_start = 0; mb_has_ldc = ldc; mb_is_inter = inter;
    end
    wait (mbd_cnt != prev);
    repeat (4) @(negedge clk);
    chk(mbd_cnt == prev + 1, "R8", mbd_cnt - prev, 1);
    chk(q0.size() == 0 && q1.size() == 0, poke ? "R9" : "R5", q0.size() + q1.size(), 0);
    chk(q2.size() == 0, "R5", q2.size(), 0);
    if (inter) chk(ipr_cnt == 0, "R7", ipr_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    repeat (6) begin
      @(negedge clk);
      chk(!ent_start && !iqt_start && !ipr_start && !mb_done, "R1",
          {ent_start, iqt_start, ipr_start, mb_done}, 0);
    end
    run_mb(1, 0, 0);
    run_mb(0, 0, 0);
    run_mb(1, 1, 0);
    run_mb(0, 1, 0);
    run_mb(1, 0, 1);
    run_mb(0, 1, 1);
    for (int k = 0; k < 4; k++) run_mb(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule